// File: doc/BRIEF.md
# Interrupt Aggregator for a Multi-Pipe DMA Controller

This block gathers event pulses from a configurable number of DMA pipes and from the controller core. It turns them into one level interrupt line for each execution environment. Each pipe has a sticky six-bit status word, a per-bit enable word and a write-to-clear port. The controller core has its own sticky status word, with an enable word and a clear port at the same bit positions. A pipe is pending when any of its status bits is set together with the matching enable bit. The controller core is pending under the same rule applied to its own words.

Every execution environment has its own mask. Bits 0 to 30 of the mask select which pending pipes reach that environment. Bit 31 of the mask selects whether the pending controller core reaches it. The masked result forms the environment's source word: bit p holds pipe p and bit 31 holds the controller core. The environment's interrupt line is high while any bit of its source word is set. Software uses a simple register port to read these words and to write the enables, the masks and the clear ports.

Top module: `irq_aggr_top`

Register offsets are byte addresses on `reg_addr`:
- 0x000: identity word, read-only.
- 0x004: pipe-count word, read-only.
- 0x010: controller status, read-only.
- 0x014: controller enable.
- 0x018: controller clear, write-only.
- 0x100 + 16·e: source word of environment e, read-only.
- 0x104 + 16·e: mask of environment e.
- 0x200 + 16·p: status of pipe p, read-only.
- 0x204 + 16·p: enable of pipe p.
- 0x208 + 16·p: clear of pipe p, write-only.

Any unmapped address and any write-only address reads as zero.

## Requirements
- R1: After reset every pipe status, the controller status, the controller enable and every environment mask read 0. Every pipe enable reads 0x31 (bits 0, 4 and 5 set), and `irq_out` is all zero.
- R2: A pulse on bit b of a pipe's event group sets bit b of that pipe's status word at the next clock edge. The bit is set whether or not the matching enable bit is set, and it stays set until it is cleared. The pipe bits are: 0 descriptor done, 1 timer, 2 wake, 3 descriptors exhausted, 4 error, 5 transfer end.
- R3: A write of value v to a pipe's clear address clears exactly the status bits of that pipe that are set in v. The same rule applies to the controller clear address and the controller status word.
- R4: When an event and a clear hit the same status bit in the same cycle, the bit is set after the edge.
- R5: Bit p of an environment's source word is 1 exactly when pipe p has a status bit set with the matching enable bit set and the environment's mask bit p is set. Status bits that are not enabled contribute nothing.
- R6: Pulses on `ctl_evt[3:0]` set controller status bits 4:1, in order: bus response error, error, empty, timer. Bit 31 of an environment's source word is 1 exactly when the controller status ANDed with the controller enable is nonzero and the environment's mask bit 31 is set.
- R7: `irq_out[e]` is high whenever environment e's source word is nonzero. It follows that word in the same cycle, with no added register stage.
- R8: The identity word carries the number of environments in bits 11:8 and the constant 0x13 in bits 7:0. The pipe-count word carries the number of pipes in bits 7:0.
- R9: Writes to read-only addresses leave every register unchanged. Writable words keep only their defined bits: pipe enables keep bits 5:0, the controller enable keeps bits 4:1, and masks keep bit 31 and bits below the pipe count.
- R10: A read strobe sampled at a clock edge places the addressed word on `reg_rdata` after that edge. `reg_rdata` then holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pipe_evt | input | 6·NUM_PIPES | Event pulses, six per pipe; pipe p occupies bits 6p+5:6p |
| ctl_evt | input | 4 | Controller event pulses mapped to controller status bits 4:1 |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| irq_out | output | NUM_ENV | Level interrupt, one per environment |

## Verification
The bench targets the race between an event and a clear on the same bit. A design that lets the clear win loses that event and shows a zero status. It checks that a timer event is latched while its enable is off, yet raises no interrupt. A design that gates latching with the enable would read zero; one that skips the enable would raise the line. It also routes pipe and controller sources to different environments, so a design that ignores masks or mixes up bit 31 drives the wrong `irq_out` lines. Finally, it writes to read-only words and writes oversized enable values, so a decoder that is too loose shows corrupted state on readback.

// File: rtl/irq_aggr_pkg.sv
package irq_aggr_pkg;
    localparam int EVW       = 6;
    localparam int CTLW      = 4;
    localparam logic [7:0]  REV_ID    = 8'h13;
    localparam logic [5:0]  PEN_RST   = 6'h31;

    localparam logic [11:0] A_REV     = 12'h000;
    localparam logic [11:0] A_NPIPE   = 12'h004;
    localparam logic [11:0] A_GSTAT   = 12'h010;
    localparam logic [11:0] A_GEN     = 12'h014;
    localparam logic [11:0] A_GCLR    = 12'h018;

    localparam logic [3:0]  OFS_SRC   = 4'h0;
    localparam logic [3:0]  OFS_MASK  = 4'h4;
    localparam logic [3:0]  OFS_PSTAT = 4'h0;
    localparam logic [3:0]  OFS_PEN   = 4'h4;
    localparam logic [3:0]  OFS_PCLR  = 4'h8;

    function automatic logic [11:0] env_addr(input int e, input logic [3:0] ofs);
        return 12'h100 + 12'(e * 16) + {8'h00, ofs};
    endfunction

    function automatic logic [11:0] pipe_addr(input int p, input logic [3:0] ofs);
        return 12'h200 + 12'(p * 16) + {8'h00, ofs};
    endfunction
endpackage

// File: rtl/irq_pipe_stat.sv
module irq_pipe_stat
    import irq_aggr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [EVW-1:0]  evt,
    input  logic            en_we,
    input  logic            clr_we,
    input  logic [EVW-1:0]  wdata,
    output logic [EVW-1:0]  stat,
    output logic [EVW-1:0]  en,
    output logic            pend
);
    logic [EVW-1:0] clr_bits;

    always_comb clr_bits = clr_we ? wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat <= '0;
        end else begin
            stat <= (stat & ~clr_bits) | evt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en <= PEN_RST;
        end else if (en_we) begin
            en <= wdata;
        end
    end

    always_comb pend = |(stat & en);
endmodule

// File: rtl/irq_ctl_stat.sv
module irq_ctl_stat
    import irq_aggr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CTLW-1:0]  evt,
    input  logic             en_we,
    input  logic             clr_we,
    input  logic [CTLW-1:0]  wdata,
    output logic [CTLW-1:0]  stat,
    output logic [CTLW-1:0]  en,
    output logic             pend
);
    logic [CTLW-1:0] clr_bits;

    always_comb clr_bits = clr_we ? wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat <= '0;
        end else begin
            stat <= (stat & ~clr_bits) | evt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en <= '0;
        end else if (en_we) begin
            en <= wdata;
        end
    end

    always_comb pend = |(stat & en);
endmodule

// File: rtl/irq_env_vec.sv
module irq_env_vec #(
    parameter int NUM_PIPES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mask_we,
    input  logic [31:0]          wdata,
    input  logic [NUM_PIPES-1:0] pipe_pend,
    input  logic                 ctl_pend,
    output logic [31:0]          mask,
    output logic [31:0]          src,
    output logic                 irq
);
    localparam logic [31:0] PIPE_BITS = (32'h1 << NUM_PIPES) - 32'h1;
    localparam logic [31:0] KEEP      = PIPE_BITS | 32'h8000_0000;

    logic [31:0] pend_vec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask <= '0;
        end else if (mask_we) begin
            mask <= wdata & KEEP;
        end
    end

    always_comb begin
        pend_vec = {ctl_pend, {(31 - NUM_PIPES){1'b0}}, pipe_pend};
        src      = pend_vec & mask;
        irq      = |src;
    end
endmodule

// File: rtl/irq_aggr_top.sv
module irq_aggr_top
    import irq_aggr_pkg::*;
#(
    parameter int NUM_PIPES = 8,
    parameter int NUM_ENV   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_PIPES*EVW-1:0] pipe_evt,
    input  logic [CTLW-1:0]          ctl_evt,
    input  logic                     reg_wr,
    input  logic                     reg_rd,
    input  logic [11:0]              reg_addr,
    input  logic [31:0]              reg_wdata,
    output logic [31:0]              reg_rdata,
    output logic [NUM_ENV-1:0]       irq_out
);
    logic [EVW-1:0]          pstat [NUM_PIPES];
    logic [EVW-1:0]          pen   [NUM_PIPES];
    logic [NUM_PIPES-1:0]    ppend;
    logic [NUM_PIPES*EVW-1:0] stat_flat;
    logic [CTLW-1:0]         gstat;
    logic [CTLW-1:0]         gen;
    logic                    gpend;
    logic [31:0]             emask [NUM_ENV];
    logic [31:0]             esrc  [NUM_ENV];
    logic [31:0]             rd_mux;

    // pipe status groups
    for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pipe
        logic en_we, clr_we;
        always_comb begin
            en_we  = reg_wr && (reg_addr == pipe_addr(p, OFS_PEN));
            clr_we = reg_wr && (reg_addr == pipe_addr(p, OFS_PCLR));
        end
        irq_pipe_stat u_pipe (
            .clk    (clk),
            .rst_n  (rst_n),
            .evt    (pipe_evt[p*EVW +: EVW]),
            .en_we  (en_we),
            .clr_we (clr_we),
            .wdata  (reg_wdata[EVW-1:0]),
            .stat   (pstat[p]),
            .en     (pen[p]),
            .pend   (ppend[p])
        );
        assign stat_flat[p*EVW +: EVW] = pstat[p];
    end

    // controller status group, bits 4:1 of the register view
    logic g_en_we, g_clr_we;
    always_comb begin
        g_en_we  = reg_wr && (reg_addr == A_GEN);
        g_clr_we = reg_wr && (reg_addr == A_GCLR);
    end

    irq_ctl_stat u_ctl (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (ctl_evt),
        .en_we  (g_en_we),
        .clr_we (g_clr_we),
        .wdata  (reg_wdata[CTLW:1]),
        .stat   (gstat),
        .en     (gen),
        .pend   (gpend)
    );

    // per-environment source words
    for (genvar e = 0; e < NUM_ENV; e++) begin : g_env
        logic mask_we;
        always_comb mask_we = reg_wr && (reg_addr == env_addr(e, OFS_MASK));
        irq_env_vec #(.NUM_PIPES(NUM_PIPES)) u_env (
            .clk       (clk),
            .rst_n     (rst_n),
            .mask_we   (mask_we),
            .wdata     (reg_wdata),
            .pipe_pend (ppend),
            .ctl_pend  (gpend),
            .mask      (emask[e]),
            .src       (esrc[e]),
            .irq       (irq_out[e])
        );
    end

    // read selection
    always_comb begin
        rd_mux = '0;
        if (reg_addr == A_REV)   rd_mux = {20'h0, 4'(NUM_ENV), REV_ID};
        if (reg_addr == A_NPIPE) rd_mux = {24'h0, 8'(NUM_PIPES)};
        if (reg_addr == A_GSTAT) rd_mux = {{(31-CTLW){1'b0}}, gstat, 1'b0};
        if (reg_addr == A_GEN)   rd_mux = {{(31-CTLW){1'b0}}, gen, 1'b0};
        for (int e = 0; e < NUM_ENV; e++) begin
            if (reg_addr == env_addr(e, OFS_SRC))  rd_mux = esrc[e];
            if (reg_addr == env_addr(e, OFS_MASK)) rd_mux = emask[e];
        end
        for (int p = 0; p < NUM_PIPES; p++) begin
            if (reg_addr == pipe_addr(p, OFS_PSTAT)) rd_mux = {{(32-EVW){1'b0}}, pstat[p]};
            if (reg_addr == pipe_addr(p, OFS_PEN))   rd_mux = {{(32-EVW){1'b0}}, pen[p]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            reg_rdata <= rd_mux;
        end
    end
endmodule

// File: rtl/irq_aggr_chk.sv
module irq_aggr_chk
    import irq_aggr_pkg::*;
#(
    parameter int NUM_PIPES = 8,
    parameter int NUM_ENV   = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NUM_PIPES*EVW-1:0] pipe_evt,
    input logic [CTLW-1:0]          ctl_evt,
    input logic                     reg_wr,
    input logic                     reg_rd,
    input logic [11:0]              reg_addr,
    input logic [31:0]              reg_wdata,
    input logic [31:0]              reg_rdata,
    input logic [NUM_ENV-1:0]       irq_out,
    input logic [NUM_PIPES*EVW-1:0] stat_flat,
    input logic [CTLW-1:0]          gstat
);
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> irq_out == '0);

    a_r2_sticky_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> ((stat_flat & $past(stat_flat)) == $past(stat_flat)));

    a_r3_pipe0_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == pipe_addr(0, OFS_PCLR) && pipe_evt[EVW-1:0] == '0)
        |=> ((stat_flat[EVW-1:0] & $past(reg_wdata[EVW-1:0])) == '0));

    a_r4_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((stat_flat & $past(pipe_evt)) == $past(pipe_evt)));

    a_r6_ctl_event_latched: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((gstat & $past(ctl_evt)) == $past(ctl_evt)));

    a_r5_no_status_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_flat == '0 && gstat == '0) |-> irq_out == '0);

    a_r8_identity_env_count: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == A_REV) |=> reg_rdata[11:8] == 4'(NUM_ENV));
endmodule

bind irq_aggr_top irq_aggr_chk #(.NUM_PIPES(NUM_PIPES), .NUM_ENV(NUM_ENV)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pipe_evt  (pipe_evt),
    .ctl_evt   (ctl_evt),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_out   (irq_out),
    .stat_flat (stat_flat),
    .gstat     (gstat)
);

// File: tb/irq_aggr_top_tb.sv
module irq_aggr_top_tb;
    import irq_aggr_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 8;
    localparam int NE = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NP*EVW-1:0] pipe_evt = '0;
    logic [CTLW-1:0]   ctl_evt = '0;
    logic              reg_wr = 1'b0;
    logic              reg_rd = 1'b0;
    logic [11:0]       reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic [NE-1:0]     irq_out;

    int n_chk = 0;
    int n_bad = 0;
    logic rd_q = 1'b0;
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_aggr_top #(.NUM_PIPES(NP), .NUM_ENV(NE)) u_dut (
        .clk(clk), .rst_n(rst_n), .pipe_evt(pipe_evt), .ctl_evt(ctl_evt),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
    );

    // monitor: a read strobed at one edge is compared at the following negedge
    always @(posedge clk) rd_q <= reg_rd;

    always @(negedge clk) begin
        if (rd_q) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_chk++;
            if (reg_rdata !== e) begin
                n_bad++;
                $display("FAIL %s: read got %h expected %h", t, reg_rdata, e);
            end
        end
    end

    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
        reg_addr = a; reg_rd = 1'b1;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic pevt(input int p, input logic [5:0] b);
        pipe_evt[p*EVW +: EVW] = b;
        @(negedge clk);
        pipe_evt = '0;
    endtask

    task automatic chk_irq(input logic [NE-1:0] e, input string t);
        n_chk++;
        if (irq_out !== e) begin
            n_bad++;
            $display("FAIL %s: irq_out got %b expected %b", t, irq_out, e);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not finish, got hang expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        chk_irq('0, "R1 irq after reset");
        rd(pipe_addr(0, OFS_PEN), 32'h31, "R1 pipe0 enable reset");
        rd(pipe_addr(3, OFS_PSTAT), 32'h0, "R1 pipe3 status reset");
        rd(A_GSTAT, 32'h0, "R1 ctl status reset");
        rd(A_GEN, 32'h0, "R1 ctl enable reset");
        rd(env_addr(0, OFS_MASK), 32'h0, "R1 env0 mask reset");

        // R8 identity, R10 read latency
        rd(A_REV, {20'h0, 4'(NE), 8'h13}, "R8 identity word (R10 latency)");
        rd(A_NPIPE, 32'd8, "R8 pipe count");

        // R2 timer event latched although disabled; R5 not contributing
        pevt(2, 6'h02);
        rd(pipe_addr(2, OFS_PSTAT), 32'h02, "R2 disabled timer bit latched");
        wr(env_addr(0, OFS_MASK), 32'h0000_0004);
        rd(env_addr(0, OFS_SRC), 32'h0, "R5 disabled bit gives no source");
        chk_irq('0, "R5 no irq from disabled bit");

        // R5/R7 enabled transfer-end bit reaches env0 only
        pevt(2, 6'h20);
        rd(pipe_addr(2, OFS_PSTAT), 32'h22, "R2 sticky accumulate");
        rd(env_addr(0, OFS_SRC), 32'h4, "R5 env0 source pipe2");
        rd(env_addr(1, OFS_SRC), 32'h0, "R5 env1 masked off");
        chk_irq(4'b0001, "R7 env0 irq");

        // R3 selective clear
        wr(pipe_addr(2, OFS_PCLR), 32'h20);
        rd(pipe_addr(2, OFS_PSTAT), 32'h02, "R3 clear only bit5");
        chk_irq(4'b0000, "R7 irq drops after clear");
        wr(pipe_addr(2, OFS_PCLR), 32'h02);
        rd(pipe_addr(2, OFS_PSTAT), 32'h00, "R3 clear bit1");

        // R4 event and clear in the same cycle
        pipe_evt[2*EVW +: EVW] = 6'h01;
        wr(pipe_addr(2, OFS_PCLR), 32'h01);
        pipe_evt = '0;
        rd(pipe_addr(2, OFS_PSTAT), 32'h01, "R4 event wins over clear");
        chk_irq(4'b0001, "R4 irq kept");
        wr(pipe_addr(2, OFS_PCLR), 32'h3F);
        chk_irq(4'b0000, "R3 full clear");

        // R6 controller path via bit 31
        ctl_evt = 4'b0010;
        @(negedge clk);
        ctl_evt = '0;
        rd(A_GSTAT, 32'h04, "R6 ctl error bit2 latched");
        rd(env_addr(1, OFS_SRC), 32'h0, "R6 ctl not enabled");
        wr(A_GEN, 32'h04);
        wr(env_addr(1, OFS_MASK), 32'h8000_0000);
        rd(env_addr(1, OFS_SRC), 32'h8000_0000, "R6 env1 bit31");
        chk_irq(4'b0010, "R7 env1 irq from ctl");
        wr(A_GCLR, 32'h04);
        rd(A_GSTAT, 32'h0, "R3 ctl clear");
        chk_irq(4'b0000, "R6 ctl irq gone");

        // R9 writes to read-only words and field widths
        wr(pipe_addr(2, OFS_PSTAT), 32'hFF);
        rd(pipe_addr(2, OFS_PSTAT), 32'h0, "R9 status write ignored");
        wr(A_REV, 32'hFFFF_FFFF);
        rd(A_REV, {20'h0, 4'(NE), 8'h13}, "R9 identity write ignored");
        wr(env_addr(1, OFS_SRC), 32'hFFFF_FFFF);
        rd(env_addr(1, OFS_SRC), 32'h0, "R9 source write ignored");
        chk_irq(4'b0000, "R9 irq unchanged");
        wr(pipe_addr(5, OFS_PEN), 32'hFFFF_FFFF);
        rd(pipe_addr(5, OFS_PEN), 32'h3F, "R9 pipe enable width");
        wr(A_GEN, 32'hFFFF_FFFF);
        rd(A_GEN, 32'h1E, "R9 ctl enable width");
        wr(env_addr(3, OFS_MASK), 32'hFFFF_FFFF);
        rd(env_addr(3, OFS_MASK), 32'h8000_00FF, "R9 mask width");

        // R5/R7 one pipe fanned to two environments
        wr(env_addr(2, OFS_MASK), 32'h80);
        pevt(7, 6'h10);
        chk_irq(4'b1100, "R7 pipe7 to env2 and env3");
        rd(env_addr(3, OFS_SRC), 32'h80, "R5 env3 source pipe7");

        @(negedge clk);
        @(negedge clk);
        finish_run();
    end
endmodule